// File: doc/BRIEF.md
# Card Swipe Time-out and Interrupt Status Collector

This block sits beside the three track timers of a card swipe reader. Each track's timer sends a one-cycle pulse when it times out. Other parts of the reader send one-cycle pulses when an auxiliary conversion completes, when the sample buffer underflows or overflows, and when a level event occurs. The block holds every such event in its own status bit. These bits stay set until software writes a one to each bit it wants to clear. The interrupt request goes high whenever a set status bit has its matching enable bit set.

The block also tells the end of a swipe apart from the time-out of a single track. For each track it keeps two flags: one records that the track's timer has started, the other that the track has timed out. The block raises a card-level time-out when a track times out and every other track is in one of these states:
- disabled,
- already timed out,
- timing out in the same cycle,
- never started.

Software can then service one interrupt per swipe instead of one per track.

Top module: `swipe_irq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `status`, `card_timeout` and `irq` are all zero.
- R2: A pulse on `trk_timeout[i]` sets `status[i]` (bits 0..TRACKS-1) on the next clock edge, whatever the value of `irq_enable`.
- R3: `aux_done`, `fifo_underflow`, `fifo_overflow` and `level_event` set status bits TRACKS+1, TRACKS+2, TRACKS+3 and TRACKS+4 respectively (bits 4..7 with three tracks) on the next edge, whatever the value of `irq_enable`.
- R4: A status bit stays set until a cycle with `clr_write` high and a one in the same bit of `clr_mask`. Zero bits of the mask, and any mask while `clr_write` is low, leave the status unchanged.
- R5: If a set event and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R6: Status bit TRACKS (bit 3), which is also driven on `card_timeout`, sets on the edge after a track times out while every other track is disabled, already timed out, or never restarted since it was last enabled.
- R7: A track time-out does not set the card bit while any other track is enabled, started and not yet timed out.
- R8: Tracks that time out in the same cycle count as timed out for each other, so a simultaneous last time-out still raises the card bit.
- R9: A `trk_restart` pulse on an enabled track marks it started and clears its timed-out flag. If restart and time-out arrive together, restart wins. A track with `trk_enabled` low loses both flags.
- R10: `irq` is a register. It is high in the cycle after one in which `status & irq_enable` is non-zero, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_timeout | input | TRACKS | Per-track time-out pulse |
| trk_enabled | input | TRACKS | Per-track enable level |
| trk_restart | input | TRACKS | Per-track timer (re)start pulse on a threshold crossing |
| aux_done | input | 1 | Auxiliary conversion complete pulse |
| fifo_underflow | input | 1 | Sample buffer underflow pulse |
| fifo_overflow | input | 1 | Sample buffer overflow pulse |
| level_event | input | 1 | Level event pulse |
| irq_enable | input | TRACKS+5 | Interrupt enable per status bit |
| clr_write | input | 1 | Status clear write strobe |
| clr_mask | input | TRACKS+5 | Write-one-to-clear mask |
| status | output | TRACKS+5 | Sticky status vector |
| card_timeout | output | 1 | Card time-out status bit |
| irq | output | 1 | Registered, level-sensitive interrupt request |

## Verification
The assertions check four properties on every cycle:
- a set bit stays set unless it was cleared;
- a bit never rises without an event;
- a set always beats a clear;
- the interrupt line follows the enabled status one cycle later.

They also check that a restart or a disable updates the per-track flags. Only the bench scenarios can show whether the card decision is right. For that, the bench sweeps:
- swipes in which tracks finish in different orders;
- a track left disabled;
- a track that never started;
- simultaneous time-outs;
- a track restarted after it had already timed out.

// File: rtl/swipe_irq_pkg.sv
package swipe_irq_pkg;

    // Offsets of the non-track events above the card time-out bit.
    localparam int OFS_AUX  = 1;
    localparam int OFS_UFLO = 2;
    localparam int OFS_OFLO = 3;
    localparam int OFS_LVL  = 4;
    localparam int EXTRA_BITS = 5;  // card bit plus four misc events

    typedef struct packed {
        logic started;
        logic expired;
    } trk_state_t;

    // A track no longer blocks the card time-out.
    function automatic logic trk_settled(logic en, trk_state_t st, logic to_now);
        return !en || st.expired || to_now || !st.started;
    endfunction

endpackage

// File: rtl/swipe_track_state.sv
module swipe_track_state
    import swipe_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enabled,
    input  logic       restart,
    input  logic       timeout,
    output trk_state_t state
);

    always_ff @(posedge clk) begin
        if (rst || !enabled) begin
            state <= '0;
        end else if (restart) begin
            state.started <= 1'b1;
            state.expired <= 1'b0;
        end else if (timeout) begin
            state.expired <= 1'b1;
        end
    end

    // R9: restart on an enabled track marks it started and not expired
    a_r9_restart_rearms: assert property (@(posedge clk) disable iff (rst)
        (enabled && restart) |=> (state.started && !state.expired));

    // R9: disabling a track drops both flags
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> (state == '0));

endmodule

// File: rtl/swipe_last_track.sv
module swipe_last_track
    import swipe_irq_pkg::*;
#(
    parameter int TRACKS = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TRACKS-1:0]        timeout,
    input  logic [TRACKS-1:0]        enabled,
    input  trk_state_t [TRACKS-1:0]  states,
    output logic                     card_evt
);

    logic [TRACKS-1:0] settled;
    logic [TRACKS-1:0] fire;

    generate
        for (genvar g = 0; g < TRACKS; g++) begin : g_settled
            assign settled[g] = trk_settled(enabled[g], states[g], timeout[g]);
        end
    endgenerate

    always_comb begin
        for (int t = 0; t < TRACKS; t++) begin
            fire[t] = timeout[t];
            for (int o = 0; o < TRACKS; o++) begin
                if (o != t && !settled[o]) fire[t] = 1'b0;
            end
        end
    end

    assign card_evt = |fire;

    // R6: a card time-out is only raised in a cycle with a track time-out
    a_r6_card_needs_timeout: assert property (@(posedge clk) disable iff (rst)
        card_evt |-> (|timeout));

endmodule

// File: rtl/swipe_status_reg.sv
module swipe_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    logic [W-1:0] clr_eff;
    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | set_vec;
    end

    // R4: uncleared bits hold
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        ((status & ~clr_eff) != '0) |=>
        ((status & $past(status & ~clr_eff)) == $past(status & ~clr_eff)));

    // R5: a set event always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R2: no bit rises without an event
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/swipe_irq_ctrl.sv
module swipe_irq_ctrl
    import swipe_irq_pkg::*;
#(
    parameter  int TRACKS = 3,
    localparam int STAT_W = TRACKS + EXTRA_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TRACKS-1:0] trk_timeout,
    input  logic [TRACKS-1:0] trk_enabled,
    input  logic [TRACKS-1:0] trk_restart,
    input  logic              aux_done,
    input  logic              fifo_underflow,
    input  logic              fifo_overflow,
    input  logic              level_event,
    input  logic [STAT_W-1:0] irq_enable,
    input  logic              clr_write,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status,
    output logic              card_timeout,
    output logic              irq
);

    localparam int CARD_BIT = TRACKS;

    trk_state_t [TRACKS-1:0] trk_st;
    logic                    card_evt;
    logic [STAT_W-1:0]       set_vec;

    generate
        for (genvar g = 0; g < TRACKS; g++) begin : g_trk
            swipe_track_state u_trk (
                .clk     (clk),
                .rst     (rst),
                .enabled (trk_enabled[g]),
                .restart (trk_restart[g]),
                .timeout (trk_timeout[g]),
                .state   (trk_st[g])
            );
        end
    endgenerate

    swipe_last_track #(.TRACKS(TRACKS)) u_last (
        .clk      (clk),
        .rst      (rst),
        .timeout  (trk_timeout),
        .enabled  (trk_enabled),
        .states   (trk_st),
        .card_evt (card_evt)
    );

    always_comb begin
        set_vec = '0;
        set_vec[TRACKS-1:0]         = trk_timeout;
        set_vec[CARD_BIT]           = card_evt;
        set_vec[CARD_BIT+OFS_AUX]   = aux_done;
        set_vec[CARD_BIT+OFS_UFLO]  = fifo_underflow;
        set_vec[CARD_BIT+OFS_OFLO]  = fifo_overflow;
        set_vec[CARD_BIT+OFS_LVL]   = level_event;
    end

    swipe_status_reg #(.W(STAT_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_en   (clr_write),
        .clr_mask (clr_mask),
        .status   (status)
    );

    assign card_timeout = status[CARD_BIT];

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & irq_enable);
    end

    // R10: enabled pending status raises the line one cycle later
    a_r10_irq_rises: assert property (@(posedge clk) disable iff (rst)
        ((status & irq_enable) != '0) |=> irq);

    // R10: no enabled pending status means the line is low one cycle later
    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        ((status & irq_enable) == '0) |=> !irq);

endmodule

// File: tb/swipe_irq_ctrl_test.sv
module swipe_irq_ctrl_test;

    localparam int NT = 3;
    localparam int SW = NT + 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] to = '0, en = '0, rs = '0;
    logic          aux = 0, ufl = 0, ofl = 0, lvl = 0;
    logic [SW-1:0] ien = '0, cmask = '0;
    logic          cwr = 1'b0;
    logic [SW-1:0] status;
    logic          card_timeout, irq;

    int checks = 0, failures = 0;

    // reference model state
    logic [SW-1:0] m_stat = '0;
    logic          m_irq = 1'b0;
    bit            m_started[NT];
    bit            m_expired[NT];

    always #4 clk = ~clk;

    swipe_irq_ctrl #(.TRACKS(NT)) uut (
        .clk(clk), .rst(rst), .trk_timeout(to), .trk_enabled(en), .trk_restart(rs),
        .aux_done(aux), .fifo_underflow(ufl), .fifo_overflow(ofl), .level_event(lvl),
        .irq_enable(ien), .clr_write(cwr), .clr_mask(cmask),
        .status(status), .card_timeout(card_timeout), .irq(irq)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: update the model from the driven inputs, advance, compare.
    task automatic tick(string req);
        logic [SW-1:0] setv;
        bit card;
        if (rst) begin
            m_stat = '0; m_irq = 1'b0;
            for (int t = 0; t < NT; t++) begin m_started[t] = 0; m_expired[t] = 0; end
        end else begin
            m_irq = (m_stat & ien) != '0;
            setv = '0; card = 0;
            for (int t = 0; t < NT; t++) begin
                if (to[t]) begin
                    bit last = 1;
                    setv[t] = 1'b1;
                    for (int o = 0; o < NT; o++)
                        if (o != t && en[o] && m_started[o] && !m_expired[o] && !to[o]) last = 0;
                    if (last) card = 1;
                end
            end
            setv[NT] = card; setv[NT+1] = aux; setv[NT+2] = ufl;
            setv[NT+3] = ofl; setv[NT+4] = lvl;
            m_stat = (m_stat & ~(cwr ? cmask : '0)) | setv;
            for (int t = 0; t < NT; t++) begin
                if (!en[t]) begin m_started[t] = 0; m_expired[t] = 0; end
                else if (rs[t]) begin m_started[t] = 1; m_expired[t] = 0; end
                else if (to[t]) m_expired[t] = 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "status", int'(status), int'(m_stat));
        check(req, "card_timeout", int'(card_timeout), int'(m_stat[NT]));
        check(req, "irq", int'(irq), int'(m_irq));
        to = '0; rs = '0; aux = 0; ufl = 0; ofl = 0; lvl = 0; cwr = 0; cmask = '0;
    endtask

    task automatic clear_all(string req);
        cwr = 1; cmask = '1; tick(req);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        tick("R1"); tick("R1");
        rst = 0; tick("R1");

        // R2: track time-outs set status with interrupts disabled
        en = '1;
        to = 3'b001; tick("R2");
        to = 3'b100; tick("R2");
        tick("R2");
        clear_all("R4");

        // R3: misc events
        aux = 1; tick("R3");
        ufl = 1; lvl = 1; tick("R3");
        ofl = 1; tick("R3");

        // R4: clear ignored without strobe, partial W1C with it
        cmask = '1; tick("R4");
        cwr = 1; cmask = 8'b0001_0000; tick("R4");
        cwr = 1; cmask = 8'b1010_0000; tick("R4");
        clear_all("R4");

        // R5: set and clear collide
        aux = 1; tick("R5");
        aux = 1; cwr = 1; cmask = 8'b0001_0000; tick("R5");
        clear_all("R5");

        // R6/R7: all enabled and started, tracks finish in order
        rs = '1; tick("R9");
        to = 3'b001; tick("R7");
        to = 3'b010; tick("R7");
        to = 3'b100; tick("R6");
        clear_all("R6");

        // R6: only track 0 enabled
        en = 3'b000; tick("R9");
        en = 3'b001; rs = 3'b001; tick("R9");
        to = 3'b001; tick("R6");
        clear_all("R6");

        // R6: track 2 never started
        en = '1; rs = 3'b011; tick("R9");
        to = 3'b010; tick("R7");
        to = 3'b001; tick("R6");
        clear_all("R6");

        // R8: simultaneous final time-outs
        en = 3'b000; tick("R9");
        en = '1; rs = '1; tick("R9");
        to = 3'b100; tick("R7");
        to = 3'b011; tick("R8");
        clear_all("R8");
        // R8: all three together
        rs = '1; tick("R9");
        to = 3'b111; tick("R8");
        clear_all("R8");

        // R9: restart re-arms an expired track
        rs = '1; tick("R9");
        to = 3'b001; tick("R7");
        rs = 3'b001; tick("R9");
        to = 3'b010; tick("R9");
        to = 3'b100; tick("R9");
        to = 3'b001; tick("R9");
        clear_all("R9");
        // R9: restart and time-out together, restart wins
        rs = '1; tick("R9");
        to = 3'b011; tick("R9");
        rs = 3'b100; to = 3'b100; tick("R9");
        to = 3'b100; tick("R9");
        clear_all("R9");
        // R9: disable drops started flag of track 1
        rs = '1; tick("R9");
        en = 3'b101; tick("R9");
        en = '1; tick("R9");
        to = 3'b001; tick("R9");
        to = 3'b100; tick("R9");
        clear_all("R9");

        // R10: interrupt follows enabled status
        ien = 8'b0000_0010; tick("R10");
        to = 3'b001; tick("R10");
        tick("R10");
        to = 3'b010; tick("R10");
        tick("R10");
        cwr = 1; cmask = 8'b0000_0010; tick("R10");
        tick("R10");
        ien = 8'b0000_0001; tick("R10");
        tick("R10");
        ien = '0; tick("R10");
        tick("R10");
        clear_all("R10");
        tick("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule